// File: doc/BRIEF.md
# DMA Channel Status Flags

This block keeps the 8-bit status byte of a single DMA channel. The transfer engine sends it one-cycle event strobes: a repeat unit finished, a block finished, the source address left its extended repeat area, the destination address left its extended repeat area, and the whole transfer finished. The block qualifies each strobe against the channel's mode and interrupt-enable settings. It then sets one of two sticky flags: an escape-end flag or a transfer-end flag.

Software reads the byte over a simple register bus, and the read data is returned in the same cycle. Software can only clear a flag, by writing 0 to its bit. A flag is also cleared when the channel is started again, which arrives here as a strobe. Each flag drives its own interrupt request. The byte also shows a read-only bit that tells whether the channel is running.

Top module: `dma_chan_status`

## Requirements
- R1: After reset, both flags and both interrupt requests are 0, and the byte reads as 0 while the active input is 0.
- R2: With `bus_sel` high, `bus_rdata` has bit 7 = `chan_active`, bit 4 = transfer-end flag and bit 0 = escape-end flag. Bits 6:5 and 3:1 read 0. With `bus_sel` low, `bus_rdata` is 0.
- R3: `evt_unit_done` with `mode` = 2'b01 (repeat) and `rpt_ie` = 1 sets the escape-end flag at the next clock edge.
- R4: `evt_block_done` with `mode` = 2'b10 (block) and `rpt_ie` = 1 sets the escape-end flag at the next clock edge.
- R5: `evt_src_ovf` with `src_ovf_ie` = 1 and a nonzero `src_area` sets the escape-end flag at the next clock edge.
- R6: `evt_dst_ovf` with `dst_ovf_ie` = 1 and a nonzero `dst_area` sets the escape-end flag at the next clock edge.
- R7: An escape event whose qualifier fails leaves the escape-end flag unchanged. Failing qualifiers are a wrong mode (2'b00 or 2'b11 count as neither repeat nor block), a 0 enable, or a zero area field.
- R8: A bus write (`bus_sel` and `bus_wr`) with data bit 0 or bit 4 at 0 clears that flag. A 1 in that bit leaves the flag unchanged. Writes to bits 7, 6:5 and 3:1 have no effect.
- R9: An `enable_strobe` pulse clears both flags at the next clock edge.
- R10: `evt_xfer_done` sets the transfer-end flag at the next clock edge.
- R11: When a set condition and a clear (bus write of 0 or `enable_strobe`) occur in the same cycle, the flag ends up set.
- R12: `irq_escape` and `irq_xfer_end` always equal the escape-end and transfer-end flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_unit_done | input | 1 | One repeat unit finished |
| evt_block_done | input | 1 | One block finished |
| evt_src_ovf | input | 1 | Source extended repeat area overflow |
| evt_dst_ovf | input | 1 | Destination extended repeat area overflow |
| evt_xfer_done | input | 1 | Whole transfer finished |
| enable_strobe | input | 1 | Channel transfer enable written with 1 |
| chan_active | input | 1 | Channel running (1) or suspended (0) |
| mode | input | 2 | 00 normal, 01 repeat, 10 block, 11 treated as normal |
| rpt_ie | input | 1 | Repeat/block escape interrupt enable |
| src_ovf_ie | input | 1 | Source overflow interrupt enable |
| dst_ovf_ie | input | 1 | Destination overflow interrupt enable |
| src_area | input | 5 | Source repeat area size, 0 = none |
| dst_area | input | 5 | Destination repeat area size, 0 = none |
| bus_sel | input | 1 | Status byte addressed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq_escape | output | 1 | Escape-end interrupt request |
| irq_xfer_end | output | 1 | Transfer-end interrupt request |

## Verification
Directed phases fire each escape event first with all of its qualifiers met and then with one qualifier failed at a time. This shows that each enable, each mode value and each area field gates only its own event. Write patterns of all-ones, all-zeros and single cleared bits show which bit each flag answers to and that the reserved positions are inert. Set events placed in the same cycle as a clear show the priority. A long random run mixes every input against a behavioural model each clock, to catch interactions the directed phases miss.

// File: rtl/dmast_pkg.sv
package dmast_pkg;
  localparam int REG_W     = 8;
  localparam int POS_ESC   = 0;
  localparam int POS_TEND  = 4;
  localparam int POS_ACT   = 7;
  localparam int NUM_FLAGS = 2;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_REPEAT = 2'b01,
    MODE_BLOCK  = 2'b10,
    MODE_RSVD   = 2'b11
  } xfer_mode_e;

  // flag index 0 is escape-end, 1 is transfer-end
  function automatic int flag_pos(input int idx);
    return (idx == 0) ? POS_ESC : POS_TEND;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic act,
                                                   input logic tend,
                                                   input logic esc);
    logic [REG_W-1:0] v;
    v = '0;
    v[POS_ACT]  = act;
    v[POS_TEND] = tend;
    v[POS_ESC]  = esc;
    return v;
  endfunction
endpackage

// File: rtl/dmast_escape_qual.sv
module dmast_escape_qual #(
  parameter int AREA_W = 5
) (
  input  logic              evt_unit_done,
  input  logic              evt_block_done,
  input  logic              evt_src_ovf,
  input  logic              evt_dst_ovf,
  input  logic [1:0]        mode,
  input  logic              rpt_ie,
  input  logic              src_ovf_ie,
  input  logic              dst_ovf_ie,
  input  logic [AREA_W-1:0] src_area,
  input  logic [AREA_W-1:0] dst_area,
  output logic              hit_unit,
  output logic              hit_block,
  output logic              hit_src,
  output logic              hit_dst,
  output logic              esc_set
);
  import dmast_pkg::*;

  function automatic logic area_on(input logic [AREA_W-1:0] a);
    return |a;
  endfunction

  xfer_mode_e mode_e;
  assign mode_e = xfer_mode_e'(mode);

  assign hit_unit  = evt_unit_done  && rpt_ie && (mode_e == MODE_REPEAT);
  assign hit_block = evt_block_done && rpt_ie && (mode_e == MODE_BLOCK);
  assign hit_src   = evt_src_ovf && src_ovf_ie && area_on(src_area);
  assign hit_dst   = evt_dst_ovf && dst_ovf_ie && area_on(dst_area);
  assign esc_set   = hit_unit | hit_block | hit_src | hit_dst;
endmodule

// File: rtl/dmast_flag.sv
module dmast_flag #(
  parameter int REG_W   = 8,
  parameter int BIT_POS = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             sw_wr_i,
  input  logic [REG_W-1:0] sw_wdata_i,
  input  logic             restart_i,
  output logic             flag_o
);
  logic sw_clear;
  logic any_clear;
  logic unused_wbits;

  assign unused_wbits = ^sw_wdata_i;
  assign sw_clear  = sw_wr_i && !sw_wdata_i[BIT_POS];
  assign any_clear = sw_clear || restart_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_o <= 1'b0;
    else if (set_i)      flag_o <= 1'b1;
    else if (any_clear)  flag_o <= 1'b0;
  end

  // R11: a set wins over any clear in the same cycle
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R8 / R9: a clear with no set empties the flag
  assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_clear && !set_i) |=> !flag_o);
  // R8: a write of 1 with no set or restart keeps the flag
  assert_write_one_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && sw_wdata_i[BIT_POS] && !set_i && !restart_i) |=> $stable(flag_o));
endmodule

// File: rtl/dmast_readmux.sv
module dmast_readmux #(
  parameter int REG_W = 8
) (
  input  logic             bus_sel,
  input  logic             chan_active,
  input  logic             flag_tend,
  input  logic             flag_esc,
  output logic [REG_W-1:0] rdata
);
  import dmast_pkg::*;

  always_comb begin
    rdata = '0;
    if (bus_sel) rdata = pack_status(chan_active, flag_tend, flag_esc);
  end
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status #(
  parameter int AREA_W = 5,
  parameter int REG_W  = dmast_pkg::REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_unit_done,
  input  logic              evt_block_done,
  input  logic              evt_src_ovf,
  input  logic              evt_dst_ovf,
  input  logic              evt_xfer_done,
  input  logic              enable_strobe,
  input  logic              chan_active,
  input  logic [1:0]        mode,
  input  logic              rpt_ie,
  input  logic              src_ovf_ie,
  input  logic              dst_ovf_ie,
  input  logic [AREA_W-1:0] src_area,
  input  logic [AREA_W-1:0] dst_area,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_escape,
  output logic              irq_xfer_end
);
  import dmast_pkg::*;

  logic hit_unit, hit_block, hit_src, hit_dst, esc_set;
  logic sw_write;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_q;

  assign sw_write = bus_sel && bus_wr;

  dmast_escape_qual #(.AREA_W(AREA_W)) qual_i (
    .evt_unit_done (evt_unit_done),
    .evt_block_done(evt_block_done),
    .evt_src_ovf   (evt_src_ovf),
    .evt_dst_ovf   (evt_dst_ovf),
    .mode          (mode),
    .rpt_ie        (rpt_ie),
    .src_ovf_ie    (src_ovf_ie),
    .dst_ovf_ie    (dst_ovf_ie),
    .src_area      (src_area),
    .dst_area      (dst_area),
    .hit_unit      (hit_unit),
    .hit_block     (hit_block),
    .hit_src       (hit_src),
    .hit_dst       (hit_dst),
    .esc_set       (esc_set)
  );

  assign flag_set[0] = esc_set;
  assign flag_set[1] = evt_xfer_done;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    dmast_flag #(.REG_W(REG_W), .BIT_POS(flag_pos(g))) flag_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (flag_set[g]),
      .sw_wr_i   (sw_write),
      .sw_wdata_i(bus_wdata),
      .restart_i (enable_strobe),
      .flag_o    (flag_q[g])
    );
  end

  assign irq_escape   = flag_q[0];
  assign irq_xfer_end = flag_q[1];

  dmast_readmux #(.REG_W(REG_W)) rd_i (
    .bus_sel    (bus_sel),
    .chan_active(chan_active),
    .flag_tend  (flag_q[1]),
    .flag_esc   (flag_q[0]),
    .rdata      (bus_rdata)
  );

  // R2: reserved positions never read as 1
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[6:5] == 2'b00 && bus_rdata[3:1] == 3'b000);
  // R12: interrupt requests agree with what the bus reads
  assert_irq_matches_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> (bus_rdata[0] == irq_escape && bus_rdata[4] == irq_xfer_end));
  // R7: without a qualified hit and without clears the escape flag holds
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!esc_set && !enable_strobe && !sw_write) |=> $stable(irq_escape));
  // R3: a repeat-unit hit always sets the escape flag
  assert_unit_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_unit |=> irq_escape);
  // R5 / R6: address overflow hits set the escape flag
  assert_ovf_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_src || hit_dst) |=> irq_escape);
  // R10: transfer completion sets the transfer-end flag
  assert_tend_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_xfer_done |=> irq_xfer_end);
  // R4: block hit only possible in block mode
  assert_block_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_block |-> (mode == 2'b10));
endmodule

// File: tb/dma_chan_status_tb.sv
module dma_chan_status_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_unit_done = 0, evt_block_done = 0, evt_src_ovf = 0, evt_dst_ovf = 0;
  logic evt_xfer_done = 0, enable_strobe = 0, chan_active = 0;
  logic [1:0] mode = 2'b00;
  logic rpt_ie = 0, src_ovf_ie = 0, dst_ovf_ie = 0;
  logic [4:0] src_area = 0, dst_area = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic irq_escape, irq_xfer_end;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  // behavioural reference state
  int m_esc = 0;
  int m_tend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_status dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expected_byte();
    int v;
    if (!bus_sel) return 0;
    v = 0;
    if (chan_active) v += 128;
    if (m_tend != 0) v += 16;
    if (m_esc != 0) v += 1;
    return v;
  endfunction

  function automatic bit esc_event();
    bit hit;
    hit = 0;
    case (mode)
      2'b01: if (evt_unit_done && rpt_ie) hit = 1;
      2'b10: if (evt_block_done && rpt_ie) hit = 1;
      default: ;
    endcase
    if (evt_src_ovf && src_ovf_ie && src_area != 0) hit = 1;
    if (evt_dst_ovf && dst_ovf_ie && dst_area != 0) hit = 1;
    return hit;
  endfunction

  // compare current outputs, then advance model and design one clock
  task automatic step(input string req);
    int nx_esc, nx_tend;
    bit wr0, wr4;
    #1;
    check({req, "/R2 rdata"}, bus_rdata, expected_byte());
    check({req, "/R12 irq_escape"}, irq_escape, m_esc);
    check({req, "/R12 irq_xfer_end"}, irq_xfer_end, m_tend);
    wr0 = bus_sel && bus_wr && !bus_wdata[0];
    wr4 = bus_sel && bus_wr && !bus_wdata[4];
    nx_esc = m_esc;
    if (wr0 || enable_strobe) nx_esc = 0;
    if (esc_event()) nx_esc = 1;
    nx_tend = m_tend;
    if (wr4 || enable_strobe) nx_tend = 0;
    if (evt_xfer_done) nx_tend = 1;
    @(posedge clk);
    @(negedge clk);
    m_esc = nx_esc;
    m_tend = nx_tend;
  endtask

  task automatic quiet();
    evt_unit_done = 0; evt_block_done = 0; evt_src_ovf = 0; evt_dst_ovf = 0;
    evt_xfer_done = 0; enable_strobe = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic clear_all();
    quiet(); enable_strobe = 1; step("R9"); quiet();
    check("R9 esc cleared", irq_escape, 0);
    check("R9 tend cleared", irq_xfer_end, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    bus_sel = 1;
    #1;
    check("R1 rdata in reset", bus_rdata, 0);
    check("R1 irq_escape in reset", irq_escape, 0);
    check("R1 irq_xfer_end in reset", irq_xfer_end, 0);
    @(negedge clk);
    rst_n = 1;
    step("R1");
    chan_active = 1; step("R2 active bit");
    chan_active = 0; step("R2 inactive");

    // R3 repeat unit
    mode = 2'b01; rpt_ie = 1; evt_unit_done = 1; step("R3");
    quiet(); step("R3"); check("R3 set", irq_escape, 1);
    clear_all();
    // R7 unit done in wrong modes or without enable
    evt_unit_done = 1; mode = 2'b10; step("R7 unit/block mode");
    mode = 2'b00; step("R7 unit/normal");
    mode = 2'b11; step("R7 unit/reserved mode");
    mode = 2'b01; rpt_ie = 0; step("R7 unit/ie off");
    quiet(); step("R7"); check("R7 unit unqualified", irq_escape, 0);

    // R4 block
    mode = 2'b10; rpt_ie = 1; evt_block_done = 1; step("R4");
    quiet(); step("R4"); check("R4 set", irq_escape, 1);
    clear_all();
    evt_block_done = 1; mode = 2'b01; step("R7 block/repeat mode");
    quiet(); step("R7"); check("R7 block unqualified", irq_escape, 0);

    // R5 source overflow
    src_ovf_ie = 1; src_area = 5'd0; evt_src_ovf = 1; step("R7 src area 0");
    src_ovf_ie = 0; src_area = 5'd3; step("R7 src ie off");
    quiet(); step("R7"); check("R7 src unqualified", irq_escape, 0);
    src_ovf_ie = 1; evt_src_ovf = 1; step("R5");
    quiet(); step("R5"); check("R5 set", irq_escape, 1);
    clear_all();

    // R6 destination overflow
    dst_ovf_ie = 1; dst_area = 5'd0; evt_dst_ovf = 1; step("R7 dst area 0");
    dst_ovf_ie = 0; dst_area = 5'd31; step("R7 dst ie off");
    quiet(); step("R7"); check("R7 dst unqualified", irq_escape, 0);
    dst_ovf_ie = 1; evt_dst_ovf = 1; step("R6");
    quiet(); step("R6"); check("R6 set", irq_escape, 1);

    // R10 transfer end
    evt_xfer_done = 1; step("R10");
    quiet(); step("R10"); check("R10 set", irq_xfer_end, 1);

    // R8 write patterns
    bus_wr = 1; bus_wdata = 8'hFF; step("R8 write ones");
    quiet(); step("R8"); check("R8 ones keep esc", irq_escape, 1);
    check("R8 ones keep tend", irq_xfer_end, 1);
    bus_wr = 1; bus_wdata = 8'hEF; step("R8 clear bit4");
    quiet(); step("R8"); check("R8 tend cleared", irq_xfer_end, 0);
    check("R8 esc kept", irq_escape, 1);
    bus_wr = 1; bus_wdata = 8'h11; step("R8 reserved zeros");
    quiet(); step("R8"); check("R8 reserved write inert", irq_escape, 1);
    bus_wr = 1; bus_wdata = 8'hFE; step("R8 clear bit0");
    quiet(); step("R8"); check("R8 esc cleared", irq_escape, 0);
    bus_sel = 0; evt_xfer_done = 1; step("R2 unselected");
    quiet(); bus_wr = 1; bus_wdata = 8'h00; step("R8 unselected write");
    quiet(); bus_sel = 1; step("R8"); check("R8 unselected ignored", irq_xfer_end, 1);

    // R11 set beats clear
    bus_wr = 1; bus_wdata = 8'h00; evt_xfer_done = 1; evt_dst_ovf = 1; step("R11");
    quiet(); step("R11"); check("R11 esc set wins", irq_escape, 1);
    check("R11 tend set wins", irq_xfer_end, 1);
    enable_strobe = 1; evt_src_ovf = 1; step("R11");
    quiet(); step("R11"); check("R11 esc over restart", irq_escape, 1);
    check("R9 tend restart", irq_xfer_end, 0);

    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      evt_unit_done  = ($urandom % 4) == 0;
      evt_block_done = ($urandom % 4) == 0;
      evt_src_ovf    = ($urandom % 5) == 0;
      evt_dst_ovf    = ($urandom % 5) == 0;
      evt_xfer_done  = ($urandom % 6) == 0;
      enable_strobe  = ($urandom % 8) == 0;
      chan_active    = 1'($urandom);
      mode           = 2'($urandom);
      rpt_ie         = 1'($urandom);
      src_ovf_ie     = 1'($urandom);
      dst_ovf_ie     = 1'($urandom);
      src_area       = (($urandom % 3) == 0) ? 5'd0 : 5'($urandom);
      dst_area       = (($urandom % 3) == 0) ? 5'd0 : 5'($urandom);
      bus_sel        = ($urandom % 4) != 0;
      bus_wr         = ($urandom % 4) == 0;
      bus_wdata      = 8'($urandom);
      step("R11 random");
    end
    quiet();
    step("R12 final");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule